// File: doc/BRIEF.md
# Tanlock Loop Digital Core

This block is the all-digital part of a first-order tanlock phase-locked loop. An external converter supplies two signed samples at each sampling instant. One is the direct input sample. The other is a copy of the same input taken after a fixed analog delay, nominally a quarter period at the free-running frequency. The core treats the pair as one point in the plane, with the direct sample as the real part and the delayed sample as the imaginary part. It measures the full four-quadrant angle of that point and uses the angle as the loop's phase error.

The error is scaled by a single loop gain to form a signed control word. A timer-based oscillator uses the control word to set the next sampling interval. The interval is the nominal period minus the control word, bounded on both sides. The core drives a one-cycle strobe that tells the converter when to sample next.

With the nominal gain (gain numerator equal to the nominal period), an error of pi shortens the interval by half a nominal period, which is a normalized loop gain of one. After a frequency step, the loop settles with a constant non-zero residual error.

Top module: `tanlock_core`

## Requirements
- R1: A synchronous active-high reset clears `phase_err` and `ctrl_word` to zero and holds `sample_strobe` low. The first strobe after reset release comes T0_COUNT clock cycles after the release.
- R2: `sample_strobe` is high for exactly one cycle. Consecutive strobes are P cycles apart, where P = T0_COUNT − `ctrl_word`, using the control word held in the cycle just before the strobe.
- R3: `phase_err` is the angle of the point (real = direct sample, imaginary = delayed sample), 16-bit two's complement with 32768 representing pi. It is accurate to within 16 LSB and wraps at ±pi, so an angle of exactly pi reads as −32768.
- R4: `phase_err` takes its new value 13 cycles after the strobe cycle and holds it at all other times.
- R5: `ctrl_word` equals floor(`phase_err` · GAIN_NUM / 2^GAIN_SHIFT). It changes one cycle after `phase_err` does and holds at all other times.
- R6: The strobe interval P is saturated to the range T0_COUNT/4 to 7·T0_COUNT/4.
- R7: When both samples are zero, the error is exactly zero.
- R8: The samples are captured only in the strobe cycle. Changes on the sample inputs in any other cycle have no effect on `phase_err`.
- R9: At the nominal gain, with a sinusoidal input whose period is shorter than the nominal period, the loop settles. The strobe interval then averages the input period, and the residual error is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also clocks the oscillator timer |
| rst | input | 1 | Synchronous active-high reset |
| y_sample | input | 16 | Signed direct input sample |
| x_sample | input | 16 | Signed delayed input sample |
| sample_strobe | output | 1 | One-cycle sampling request to the converter |
| phase_err | output | 16 | Signed phase error, 32768 = pi |
| ctrl_word | output | 17 | Signed control word that shortens the next interval |

## Verification
On every cycle, the embedded properties check that the strobe is a single-cycle pulse and that the timer never exceeds the longest allowed interval. They also check that the error and the control word change only right after the arithmetic finishes, and that a new capture never arrives while the angle unit is busy. Other behaviour needs whole scenarios from the bench: angle accuracy across all four quadrants and at the ±pi wrap, the exact spacing of strobes as the control word moves, saturation at both ends of the interval range, immunity to input changes between strobes, and the settling of the closed loop onto a shifted input frequency with a residual error.

// File: rtl/tanlock_pkg.sv
package tanlock_pkg;

    localparam int SMP_W = 16;
    localparam int ANG_W = 16;
    localparam int VEC_W = SMP_W + 3;
    localparam int ZW    = ANG_W + 2;

    localparam logic signed [ZW-1:0] PI_Z = ZW'(2 ** (ANG_W - 1));

    typedef logic signed [ANG_W-1:0] angle_t;

    typedef struct packed {
        logic signed [VEC_W-1:0] re;
        logic signed [VEC_W-1:0] im;
        logic signed [ZW-1:0]    z;
    } rot_vec_t;

    typedef enum logic [0:0] {
        ROT_IDLE = 1'b0,
        ROT_RUN  = 1'b1
    } rot_state_e;

    // Elementary rotation angles atan(2^-i), scaled so that 2^(ANG_W-1) = pi.
    function automatic int atan_step(int idx);
        case (idx)
            0:  return 8192;
            1:  return 4836;
            2:  return 2555;
            3:  return 1297;
            4:  return 651;
            5:  return 326;
            6:  return 163;
            7:  return 81;
            8:  return 41;
            9:  return 20;
            10: return 10;
            11: return 5;
            12: return 3;
            13: return 1;
            14: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int clamp_int(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/tl_cordic_vec.sv
module tl_cordic_vec
    import tanlock_pkg::*;
#(
    parameter int ITERS = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic signed [SMP_W-1:0] re_in,
    input  logic signed [SMP_W-1:0] im_in,
    output angle_t                  ang_out,
    output logic                    done
);

    localparam int IW = $clog2(ITERS + 1);
    localparam logic [IW-1:0] LAST = IW'(ITERS - 1);

    rot_state_e             st;
    logic [IW-1:0]          iter;
    rot_vec_t               v, v_init, v_nxt;
    logic                   zero_q;
    logic signed [VEC_W-1:0] re_ext, im_ext, re_sh, im_sh;
    logic signed [ZW-1:0]   step_ang;

    assign re_ext = VEC_W'(re_in);
    assign im_ext = VEC_W'(im_in);

    // Move the left half-plane into the right one, remembering +/-pi.
    always_comb begin
        v_init.re = re_ext;
        v_init.im = im_ext;
        v_init.z  = '0;
        if (re_in < 0) begin
            v_init.re = -re_ext;
            v_init.im = -im_ext;
            v_init.z  = (im_in >= 0) ? PI_Z : -PI_Z;
        end
    end

    // One vectoring micro-rotation per cycle, driving im toward zero.
    always_comb begin
        re_sh    = v.re >>> iter;
        im_sh    = v.im >>> iter;
        step_ang = ZW'(atan_step(int'(iter)));
        v_nxt    = v;
        if (v.im >= 0) begin
            v_nxt.re = v.re + im_sh;
            v_nxt.im = v.im - re_sh;
            v_nxt.z  = v.z + step_ang;
        end else begin
            v_nxt.re = v.re - im_sh;
            v_nxt.im = v.im + re_sh;
            v_nxt.z  = v.z - step_ang;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ROT_IDLE;
            iter    <= '0;
            v       <= '0;
            zero_q  <= 1'b0;
            ang_out <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ROT_IDLE: begin
                    if (start) begin
                        v      <= v_init;
                        zero_q <= (re_in == 0) && (im_in == 0);
                        iter   <= '0;
                        st     <= ROT_RUN;
                    end
                end
                ROT_RUN: begin
                    v    <= v_nxt;
                    iter <= iter + 1'b1;
                    if (iter == LAST) begin
                        st      <= ROT_IDLE;
                        done    <= 1'b1;
                        // 2*pi equals 2^ANG_W, so truncation is the modulo wrap.
                        ang_out <= zero_q ? '0 : angle_t'(v_nxt.z);
                    end
                end
                default: st <= ROT_IDLE;
            endcase
        end
    end

    // R4: a capture never arrives while a conversion is in flight
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (st == ROT_IDLE));

    // R4: the result register moves only together with the done pulse
    result_done_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ang_out) |-> done);

endmodule

// File: rtl/tl_loop_gain.sv
module tl_loop_gain
    import tanlock_pkg::*;
#(
    parameter int GAIN_NUM   = 64,
    parameter int GAIN_W     = 16,
    parameter int GAIN_SHIFT = 16
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       load,
    input  angle_t                                     ang_in,
    output logic signed [ANG_W+GAIN_W-GAIN_SHIFT:0]    ctrl
);

    localparam int PW   = ANG_W + GAIN_W + 1;
    localparam int CW_W = PW - GAIN_SHIFT;
    localparam logic signed [GAIN_W:0] GAIN_S = (GAIN_W + 1)'(GAIN_NUM);

    logic signed [PW-1:0] prod;

    assign prod = PW'(ang_in) * PW'(GAIN_S);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (load) begin
            ctrl <= CW_W'(prod >>> GAIN_SHIFT);
        end
    end

    // R5: the control word only follows a completed error update
    ctrl_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl) |-> $past(load));

endmodule

// File: rtl/tl_dco_timer.sv
module tl_dco_timer
    import tanlock_pkg::*;
#(
    parameter int T0_COUNT = 64,
    parameter int CW_W     = 17
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [CW_W-1:0] ctrl,
    output logic                   strobe
);

    localparam int P_MIN = T0_COUNT / 4;
    localparam int P_MAX = (7 * T0_COUNT) / 4;
    localparam int CNT_W = $clog2(P_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period;

    assign period = CNT_W'(clamp_int(T0_COUNT - int'(ctrl), P_MIN, P_MAX));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else if (({1'b0, cnt} + 1'b1) >= {1'b0, period}) begin
            cnt    <= '0;
            strobe <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            strobe <= 1'b0;
        end
    end

    // R2
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    // R6
    interval_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < P_MAX);

endmodule

// File: rtl/tanlock_core.sv
module tanlock_core
    import tanlock_pkg::*;
#(
    parameter int T0_COUNT   = 64,
    parameter int ITERS      = 12,
    parameter int GAIN_NUM   = 64,
    parameter int GAIN_W     = 16,
    parameter int GAIN_SHIFT = 16
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic signed [SMP_W-1:0]                 y_sample,
    input  logic signed [SMP_W-1:0]                 x_sample,
    output logic                                    sample_strobe,
    output logic signed [ANG_W-1:0]                 phase_err,
    output logic signed [ANG_W+GAIN_W-GAIN_SHIFT:0] ctrl_word
);

    localparam int CW_W = ANG_W + GAIN_W + 1 - GAIN_SHIFT;

    logic   rot_done;
    angle_t rot_ang;

    tl_cordic_vec #(
        .ITERS (ITERS)
    ) u_rot (
        .clk     (clk),
        .rst     (rst),
        .start   (sample_strobe),
        .re_in   (y_sample),
        .im_in   (x_sample),
        .ang_out (rot_ang),
        .done    (rot_done)
    );

    assign phase_err = rot_ang;

    tl_loop_gain #(
        .GAIN_NUM   (GAIN_NUM),
        .GAIN_W     (GAIN_W),
        .GAIN_SHIFT (GAIN_SHIFT)
    ) u_gain (
        .clk    (clk),
        .rst    (rst),
        .load   (rot_done),
        .ang_in (rot_ang),
        .ctrl   (ctrl_word)
    );

    tl_dco_timer #(
        .T0_COUNT (T0_COUNT),
        .CW_W     (CW_W)
    ) u_dco (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ctrl_word),
        .strobe (sample_strobe)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (phase_err == 0 && ctrl_word == 0 && !sample_strobe));

    // R4
    err_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(phase_err) |-> rot_done);

endmodule

// File: tb/sim_tanlock_core.sv
module sim_tanlock_core;

    localparam int T0    = 64;
    localparam int G_NOM = 64;
    localparam int G_HI  = 160;
    localparam int P_LO  = T0 / 4;
    localparam int P_HI  = 7 * T0 / 4;
    localparam int T_IN  = 58;
    localparam int WD_LIMIT = 60000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [15:0] y_in = '0;
    logic signed [15:0] x_in = '0;
    logic strb0, strb1;
    logic signed [15:0] err0, err1;
    logic signed [16:0] c0, c1;

    always #4 clk = ~clk;

    tanlock_core #(.T0_COUNT(T0), .GAIN_NUM(G_NOM)) u0 (
        .clk(clk), .rst(rst), .y_sample(y_in), .x_sample(x_in),
        .sample_strobe(strb0), .phase_err(err0), .ctrl_word(c0));

    tanlock_core #(.T0_COUNT(T0), .GAIN_NUM(G_HI)) u1 (
        .clk(clk), .rst(rst), .y_sample(y_in), .x_sample(x_in),
        .sample_strobe(strb1), .phase_err(err1), .ctrl_word(c1));

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    // reference model state
    int since, pend, py, px, held_err, held_c, prev_c, since1, last_gap1;
    bit cdue;
    int mode;             // 0 hold, 1 jam between strobes, 2 sinusoid
    int good_y, good_x;
    string err_tag = "R3";
    int gaps0[$];
    int errs0[$];

    function automatic int ref_angle(int y, int x);
        real a;
        int r;
        if (y == 0 && x == 0) return 0;
        a = $atan2(real'(x), real'(y)) * 32768.0 / 3.14159265358979;
        r = int'(a);
        if (r >= 32768) r -= 65536;
        return r;
    endfunction

    function automatic int wrap_abs(int d);
        int m;
        m = ((d % 65536) + 65536) % 65536;
        if (m >= 32768) m = 65536 - m;
        return m;
    endfunction

    function automatic int gain_ref(int e, int g);
        int p;
        p = e * g;
        return p >>> 16;
    endfunction

    function automatic int period_of(int c);
        int v;
        v = T0 - c;
        if (v < P_LO) v = P_LO;
        if (v > P_HI) v = P_HI;
        return v;
    endfunction

    function automatic int sine_at(int t, int shift);
        return int'(20000.0 * $sin(2.0 * 3.14159265358979 * real'(t - shift) / real'(T_IN)));
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        int p;
        int r;
        @(negedge clk);
        cyc++;
        since++;
        // control word: one cycle behind the error (R5)
        if (cdue) begin
            check(c0 == gain_ref(held_err, G_NOM), "R5 ctrl word", c0, gain_ref(held_err, G_NOM));
            held_c = c0;
            cdue = 0;
        end else begin
            check(c0 == held_c, "R5 ctrl hold", c0, held_c);
        end
        // error: 13 cycles after the strobe cycle (R4)
        if (pend == 1) begin
            pend = 0;
            r = ref_angle(py, px);
            if (py == 0 && px == 0) check(err0 == 0, "R7 zero pair", err0, 0);
            else check(wrap_abs(int'(err0) - r) <= 16, err_tag, err0, r);
            held_err = err0;
            errs0.push_back(err0);
            cdue = 1;
        end else begin
            if (pend > 1) pend--;
            check(err0 == held_err, "R4 error hold", err0, held_err);
        end
        // strobe spacing (R2)
        p = period_of(prev_c);
        check(strb0 == (since >= p), "R2 strobe timing", strb0, (since >= p));
        if (strb0) begin
            gaps0.push_back(since);
            since = 0;
            pend = 13;
            py = y_in;
            px = x_in;
        end
        prev_c = c0;
        since1++;
        if (strb1) begin
            last_gap1 = since1;
            since1 = 0;
        end
    endtask

    task automatic step();
        tick();
        if (!strb0) begin
            if (mode == 1) begin
                if (since + 1 >= period_of(c0)) begin
                    y_in = 16'(good_y);
                    x_in = 16'(good_x);
                end else begin
                    y_in = 16'(cyc * 7919);
                    x_in = 16'(-cyc * 4513);
                end
            end else if (mode == 2) begin
                y_in = 16'(sine_at(cyc + 1, 0));
                x_in = 16'(sine_at(cyc + 1, T0 / 4));
            end
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_strobes(int n);
        int seen;
        seen = 0;
        while (seen < n) begin
            step();
            if (strb0) seen++;
        end
        step();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        y_in = '0;
        x_in = '0;
        repeat (3) @(negedge clk);
        check(err0 == 0, "R1 reset error", err0, 0);
        check(c0 == 0, "R1 reset ctrl", c0, 0);
        check(strb0 == 0, "R1 reset strobe", strb0, 0);
        since = 0; pend = -1; held_err = 0; held_c = 0; prev_c = 0;
        cdue = 0; since1 = 0; last_gap1 = 0;
        gaps0.delete();
        errs0.delete();
        rst = 1'b0;
    endtask

    task automatic apply(int y, int x);
        y_in = 16'(y);
        x_in = 16'(x);
        wait_strobes(2);
    endtask

    always @(posedge clk) begin
        if (cyc > WD_LIMIT && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int sum;
        int n;
        mode = 0;
        do_reset();

        // R1: first interval equals the nominal period; R7 with zero samples
        wait_strobes(2);
        check(gaps0.size() > 0 && gaps0[0] == T0, "R1 first strobe", gaps0.size() > 0 ? gaps0[0] : -1, T0);

        // R3: all quadrants, axes and the +/-pi wrap
        apply(20000, 0);
        apply(0, 20000);
        apply(-20000, 0);
        apply(0, -20000);
        apply(10000, -10000);
        apply(-20000, -5000);
        apply(12000, 25000);
        apply(-25000, 18000);
        apply(0, 0);
        apply(-32768, 0);

        // R8: inputs toggle in every non-strobe cycle
        err_tag = "R8";
        good_y = 12000; good_x = -7000;
        mode = 1;
        wait_strobes(3);
        good_y = -9000; good_x = 21000;
        wait_strobes(3);
        mode = 0;
        err_tag = "R3";

        // R6: high-gain instance saturates at both ends
        y_in = -16'sd30000; x_in = 16'sd100;
        run(400);
        check(last_gap1 == P_LO, "R6 low clamp", last_gap1, P_LO);
        y_in = -16'sd30000; x_in = -16'sd100;
        run(400);
        check(last_gap1 == P_HI, "R6 high clamp", last_gap1, P_HI);
        wait_strobes(1);

        // R9: closed loop on a faster sinusoid
        mode = 2;
        run(3000);
        n = gaps0.size();
        sum = 0;
        for (int i = n - 8; i < n; i++) sum += gaps0[i];
        check(sum >= 8 * T_IN - 3 && sum <= 8 * T_IN + 3, "R9 average interval", sum, 8 * T_IN);
        n = errs0.size();
        for (int i = n - 8; i < n; i++)
            check(errs0[i] >= 2048 && errs0[i] <= 12288, "R9 residual error", errs0[i], 6144);

        // R1: reset in the middle of operation restarts the timer
        mode = 0;
        do_reset();
        wait_strobes(1);
        check(gaps0.size() > 0 && gaps0[0] == T0, "R1 restart strobe", gaps0.size() > 0 ? gaps0[0] : -1, T0);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule